// File: doc/BRIEF.md
# Random Number Output and Status Register Front End

This block is the register face of a hardware random number generator. Software reads a batch of four 32-bit random words from a small register window. It then writes a one to the ready bit of the status register, and that write tells the upstream generator to deliver the next batch. The block buffers the batch as it arrives, raises ready once all four words are in place, and keeps the buffer frozen until software acknowledges it.

A sticky status word records seven health-failure causes, which arrive as single-cycle event pulses from logic outside this block. Each cause has its own interrupt enable in the control register, and the interrupt line is a level that stays high while any enabled cause is pending. The control register also holds the generator enable. Two further registers hold the refill cycle limits and the alarm threshold, and this block passes their values straight out to the generator. A read-only register reports the revision.

The refill sequencer is a four-state machine:
- **FS_IDLE**: the generator is disabled.
- **FS_FILL**: the block is requesting words and storing them in arrival order.
- **FS_PUBLISH**: a single cycle after the last word is stored.
- **FS_HOLD**: ready is set and the buffer is frozen.

The transitions are:
- IDLE→FILL when enable is high.
- FILL→PUBLISH when the last word is accepted.
- FILL→IDLE or PUBLISH→IDLE when enable drops.
- PUBLISH→HOLD otherwise.
- HOLD→FILL when ready is acknowledged with enable high.
- HOLD→IDLE when ready is acknowledged with enable low.

Top module: `rng_regif`

## Requirements
- R1: After reset, every register reads zero except the revision register, `irq` is low, `gen_req` is low, and all four output words read zero.
- R2: The output words read at byte offsets 0x00, 0x04, 0x08 and 0x0C. While `gen_req` is high, each cycle with `gen_valid` high stores `gen_data` into the next word, in order from word 0 to word 3, and cycles without `gen_valid` store nothing.
- R3: Status bit 0 (ready) reads one exactly one cycle after the fourth word is stored. `gen_req` is low from the cycle after that fourth word, and it is never high together with ready.
- R4: While ready is set, the output words and ready stay unchanged whatever `gen_valid` and `gen_data` do.
- R5: Writing status offset 0x10 with bit 0 set clears ready. If the enable bit is set, `gen_req` goes high on the following cycle. A status write with bit 0 at zero leaves ready set.
- R6: Status bits 1 to 7 are sticky and are set by `health_evt[0]` to `health_evt[6]` respectively. Bit 1 is shutdown overflow, bit 2 stuck output, bit 3 noise, bit 4 run, bit 5 long run, bit 6 poker and bit 7 monobit. An event in the same cycle as a clearing write leaves the bit set.
- R7: Writing a one to status bits 1 to 7 clears those bits, and writing a zero leaves a bit unchanged.
- R8: `irq` is high exactly when some status bit k (1 to 7) is set and control bit k is set. It stays high until that cause is cleared or its enable is removed.
- R9: The control register at 0x14 keeps bit 10 (generator enable) and bits 7:1 (interrupt enables), and its other bits read zero. While enable is low, `gen_req` stays low, generator data is ignored and ready stays low.
- R10: The configuration register at 0x18 keeps the minimum refill count in bits 7:0 and the maximum refill count in bits 31:16, and the alarm register at 0x1C keeps the threshold in bits 7:0. Other bits read zero, and `refill_min`, `refill_max` and `alarm_threshold` follow these fields.
- R11: The register at 0x7C reads the major revision in bits 27:24, the minor revision in bits 23:20 and the patch level in bits 19:16, taken from parameters, with all other bits zero.
- R12: Writes to the output word offsets have no effect, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| gen_valid | input | 1 | Generator word valid |
| gen_data | input | 32 | Generator random word |
| gen_req | output | 1 | Refill request to the generator |
| health_evt | input | 7 | Health-failure event pulses, bit k sets status bit k+1 |
| irq | output | 1 | Level interrupt |
| gen_enable | output | 1 | Generator enable from the control register |
| refill_min | output | 8 | Minimum refill cycle count |
| refill_max | output | 16 | Maximum refill cycle count |
| alarm_threshold | output | 8 | Alarm threshold |

## Verification
The assertions check on every cycle the following properties:
- request and ready are never high together;
- ready and the buffered words hold until acknowledged;
- a disabled generator never sees a request;
- every health event lands in the status word;
- the interrupt never rises without an enable.

Only the bench scenarios show the rest:
- the word order and the exact one-cycle delay of ready;
- the write-one-to-clear semantics, including the event-wins collision;
- the per-cause interrupt gating, swept over all seven causes with enables on and off;
- the field masking of the control, configuration and alarm registers.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned N_CAUSE = 7;

    // word indices (byte offset / 4)
    localparam int unsigned IDX_STATUS = 4;
    localparam int unsigned IDX_CTRL   = 5;
    localparam int unsigned IDX_CFG    = 6;
    localparam int unsigned IDX_ALARM  = 7;
    localparam int unsigned IDX_REV    = 31;

    localparam int unsigned EN_BIT     = 10;
    localparam int unsigned RMIN_W     = 8;
    localparam int unsigned RMAX_W     = 16;
    localparam int unsigned RMAX_LSB   = 16;
    localparam int unsigned ALARM_W    = 8;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_FILL    = 2'd1,
        FS_PUBLISH = 2'd2,
        FS_HOLD    = 2'd3
    } fill_state_e;

endpackage

// File: rtl/rng_word_buffer.sv
module rng_word_buffer
    import rng_regif_pkg::*;
#(
    parameter int unsigned NW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      ready_clr,
    input  logic                      gen_valid,
    input  logic [REG_W-1:0]          gen_data,
    output logic                      gen_req,
    output logic                      ready,
    output logic [NW-1:0][REG_W-1:0]  words
);

    localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(NW - 1);

    fill_state_e state_q, state_d;
    logic [CW-1:0] idx_q;
    logic          accept;

    assign accept = (state_q == FS_FILL) && gen_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (enable) state_d = FS_FILL;
            end
            FS_FILL: begin
                if (!enable)                        state_d = FS_IDLE;
                else if (accept && idx_q == LAST_IDX) state_d = FS_PUBLISH;
            end
            FS_PUBLISH: begin
                if (!enable) state_d = FS_IDLE;
                else         state_d = FS_HOLD;
            end
            FS_HOLD: begin
                if (ready_clr) state_d = enable ? FS_FILL : FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gen_req = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            FS_IDLE:    ;
            FS_FILL:    gen_req = 1'b1;
            FS_PUBLISH: ;
            FS_HOLD:    ready   = 1'b1;
            default:    ;
        endcase
    end

    // word index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q != FS_FILL) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + CW'(1);
        end
    end

    // word storage, one register per word
    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[w] <= '0;
            else if (accept && idx_q == CW'(w))
                words[w] <= gen_data;
        end
    end

endmodule

// File: rtl/rng_status_bits.sv
module rng_status_bits
    import rng_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] evt,
    input  logic [N_CAUSE-1:0] clr_mask,
    output logic [N_CAUSE-1:0] sts
);

    for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sts[c] <= 1'b0;
            else if (evt[c]) sts[c] <= 1'b1;
            else if (clr_mask[c]) sts[c] <= 1'b0;
        end
    end

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
    import rng_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [REG_W-1:0]   wdata,
    output logic               gen_en,
    output logic [N_CAUSE-1:0] irq_en,
    output logic [RMIN_W-1:0]  refill_min,
    output logic [RMAX_W-1:0]  refill_max,
    output logic [ALARM_W-1:0] alarm_thr,
    output logic [REG_W-1:0]   ctrl_rd,
    output logic [REG_W-1:0]   cfg_rd,
    output logic [REG_W-1:0]   alarm_rd
);

    logic wr_ctrl, wr_cfg, wr_alarm;
    logic unused_wdata;

    assign wr_ctrl  = wr && (idx == IDX_W'(IDX_CTRL));
    assign wr_cfg   = wr && (idx == IDX_W'(IDX_CFG));
    assign wr_alarm = wr && (idx == IDX_W'(IDX_ALARM));
    assign unused_wdata = ^{wdata[15:11], wdata[9:8]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            irq_en <= '0;
        end else if (wr_ctrl) begin
            gen_en <= wdata[EN_BIT];
            irq_en <= wdata[N_CAUSE:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refill_min <= '0;
            refill_max <= '0;
        end else if (wr_cfg) begin
            refill_min <= wdata[RMIN_W-1:0];
            refill_max <= wdata[RMAX_LSB +: RMAX_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        alarm_thr <= '0;
        else if (wr_alarm) alarm_thr <= wdata[ALARM_W-1:0];
    end

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[EN_BIT]      = gen_en;
        ctrl_rd[N_CAUSE:1]   = irq_en;
        cfg_rd               = '0;
        cfg_rd[RMIN_W-1:0]   = refill_min;
        cfg_rd[RMAX_LSB +: RMAX_W] = refill_max;
        alarm_rd             = '0;
        alarm_rd[ALARM_W-1:0] = alarm_thr;
    end

endmodule

// File: rtl/rng_regif.sv
module rng_regif
    import rng_regif_pkg::*;
#(
    parameter int unsigned NW        = 4,
    parameter int unsigned REV_MAJOR = 2,
    parameter int unsigned REV_MINOR = 1,
    parameter int unsigned REV_PATCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic                  gen_valid,
    input  logic [REG_W-1:0]      gen_data,
    output logic                  gen_req,
    input  logic [N_CAUSE-1:0]    health_evt,
    output logic                  irq,
    output logic                  gen_enable,
    output logic [RMIN_W-1:0]     refill_min,
    output logic [RMAX_W-1:0]     refill_max,
    output logic [ALARM_W-1:0]    alarm_threshold
);

    localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [REG_W-1:0] REV_WORD =
        {4'd0, 4'(REV_MAJOR), 4'(REV_MINOR), 4'(REV_PATCH), 16'd0};

    logic [IDX_W-1:0]          reg_idx;
    logic                      wr_status;
    logic                      ready_w, ready_clr_w;
    logic [N_CAUSE-1:0]        sts_w, irq_en_w, clr_mask_w;
    logic [NW-1:0][REG_W-1:0]  words_w;
    logic [REG_W-1:0]          ctrl_rd_w, cfg_rd_w, alarm_rd_w;
    logic                      unused_addr;

    assign reg_idx     = bus_addr[ADDR_W-1:2];
    assign unused_addr = ^bus_addr[1:0];
    assign wr_status   = bus_wr && (reg_idx == IDX_W'(IDX_STATUS));
    assign ready_clr_w = wr_status && bus_wdata[0];
    assign clr_mask_w  = wr_status ? bus_wdata[N_CAUSE:1] : '0;

    rng_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .idx        (reg_idx),
        .wdata      (bus_wdata),
        .gen_en     (gen_enable),
        .irq_en     (irq_en_w),
        .refill_min (refill_min),
        .refill_max (refill_max),
        .alarm_thr  (alarm_threshold),
        .ctrl_rd    (ctrl_rd_w),
        .cfg_rd     (cfg_rd_w),
        .alarm_rd   (alarm_rd_w)
    );

    rng_status_bits u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (health_evt),
        .clr_mask (clr_mask_w),
        .sts      (sts_w)
    );

    rng_word_buffer #(.NW(NW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (gen_enable),
        .ready_clr (ready_clr_w),
        .gen_valid (gen_valid),
        .gen_data  (gen_data),
        .gen_req   (gen_req),
        .ready     (ready_w),
        .words     (words_w)
    );

    assign irq = |(sts_w & irq_en_w);

    always_comb begin
        bus_rdata = '0;
        case (reg_idx)
            IDX_W'(IDX_STATUS): bus_rdata = {{(REG_W-N_CAUSE-1){1'b0}}, sts_w, ready_w};
            IDX_W'(IDX_CTRL):   bus_rdata = ctrl_rd_w;
            IDX_W'(IDX_CFG):    bus_rdata = cfg_rd_w;
            IDX_W'(IDX_ALARM):  bus_rdata = alarm_rd_w;
            IDX_W'(IDX_REV):    bus_rdata = REV_WORD;
            default: begin
                if (int'(reg_idx) < NW) bus_rdata = words_w[reg_idx[CW-1:0]];
            end
        endcase
    end

endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk
    import rng_regif_pkg::*;
#(
    parameter int unsigned NW = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     gen_req,
    input logic                     ready,
    input logic                     ready_clr,
    input logic                     gen_enable,
    input logic                     irq,
    input logic [N_CAUSE-1:0]       irq_en,
    input logic [N_CAUSE-1:0]       sts,
    input logic [N_CAUSE-1:0]       health_evt,
    input logic [NW-1:0][REG_W-1:0] words
);

    // R3
    req_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_req && ready));

    // R3
    ready_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !$past(gen_req));

    // R4
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ready_clr) |=> ready);

    // R4
    words_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ready_clr) |=> $stable(words));

    // R9
    disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_enable |=> !gen_req);

    // R6
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (health_evt != '0) |=> ((sts & $past(health_evt)) == $past(health_evt)));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en != '0));

endmodule

bind rng_regif rng_regif_chk #(.NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_req    (gen_req),
    .ready      (ready_w),
    .ready_clr  (ready_clr_w),
    .gen_enable (gen_enable),
    .irq        (irq),
    .irq_en     (irq_en_w),
    .sts        (sts_w),
    .health_evt (health_evt),
    .words      (words_w)
);

// File: tb/tb_rng_regif.sv
module tb_rng_regif;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EN = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        gen_valid = 1'b0;
    logic [31:0] gen_data = '0;
    logic        gen_req;
    logic [6:0]  health_evt = '0;
    logic        irq;
    logic        gen_enable;
    logic [7:0]  refill_min;
    logic [15:0] refill_max;
    logic [7:0]  alarm_threshold;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rng_regif dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gen_valid(gen_valid),
        .gen_data(gen_data), .gen_req(gen_req), .health_evt(health_evt),
        .irq(irq), .gen_enable(gen_enable), .refill_min(refill_min),
        .refill_max(refill_max), .alarm_threshold(alarm_threshold)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [31:0] pat(input int r, input int i);
        return 32'h9E37_79B9 * (r * 4 + i + 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [8];
        pats = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'hA5A5_A5A5,
                 32'h5A5A_5A5A, 32'h8000_0001, 32'h0000_0400, 32'hFFFF_FBFF};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(7'h10, v); chk("R1 status", v, 32'h0);
        rd(7'h14, v); chk("R1 ctrl", v, 32'h0);
        rd(7'h18, v); chk("R1 cfg", v, 32'h0);
        rd(7'h1C, v); chk("R1 alarm", v, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(7'(i * 4), v); chk("R1 word", v, 32'h0);
        end
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 gen_req", {31'd0, gen_req}, 32'h0);

        // R11 revision
        rd(7'h7C, v); chk("R11 revision", v, {4'd0, 4'd2, 4'd1, 4'd3, 16'd0});

        // R10 and R9 field masking sweep
        for (int k = 0; k < 8; k++) begin
            wr(7'h18, pats[k]); wr(7'h1C, pats[k]); wr(7'h14, pats[k]);
            rd(7'h18, v); chk("R10 cfg read", v, pats[k] & 32'hFFFF_00FF);
            rd(7'h1C, v); chk("R10 alarm read", v, pats[k] & 32'h0000_00FF);
            chk("R10 refill_min", {24'd0, refill_min}, {24'd0, pats[k][7:0]});
            chk("R10 refill_max", {16'd0, refill_max}, {16'd0, pats[k][31:16]});
            chk("R10 alarm_threshold", {24'd0, alarm_threshold}, {24'd0, pats[k][7:0]});
            rd(7'h14, v); chk("R9 ctrl read", v, pats[k] & 32'h0000_04FE);
        end
        wr(7'h14, 32'h0);
        tick();

        // R9 disabled: data ignored, no request, ready low
        gen_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            gen_data = 32'hDEAD_0000 + 32'(i);
            tick();
            chk("R9 gen_req low", {31'd0, gen_req}, 32'h0);
        end
        gen_valid = 1'b0;
        rd(7'h10, v); chk("R9 ready low", v, 32'h0);
        rd(7'h00, v); chk("R9 word0 untouched", v, 32'h0);

        // R12 data writes ignored, unmapped reads zero
        wr(7'h04, 32'hCAFE_F00D);
        rd(7'h04, v); chk("R12 word write ignored", v, 32'h0);
        rd(7'h40, v); chk("R12 unmapped", v, 32'h0);
        rd(7'h24, v); chk("R12 unmapped", v, 32'h0);

        // R2..R5 refill rounds
        wr(7'h14, EN);
        tick();
        for (int r = 0; r < 3; r++) begin
            chk("R2 gen_req high", {31'd0, gen_req}, 32'h1);
            for (int i = 0; i < 4; i++) begin
                if (r == 1) begin
                    gen_valid = 1'b0; gen_data = 32'hBAD0_0000;
                    tick();
                end
                gen_valid = 1'b1; gen_data = pat(r, i);
                tick();
            end
            gen_valid = 1'b0;
            rd(7'h10, v); chk("R3 ready not yet", v, 32'h0);
            chk("R3 gen_req dropped", {31'd0, gen_req}, 32'h0);
            tick();
            rd(7'h10, v); chk("R3 ready set", v, 32'h1);
            gen_valid = 1'b1;
            for (int j = 0; j < 3; j++) begin
                gen_data = 32'h0BAD_0BAD ^ 32'(j);
                tick();
            end
            gen_valid = 1'b0;
            for (int i = 0; i < 4; i++) begin
                rd(7'(i * 4), v); chk("R2 R4 word order and hold", v, pat(r, i));
            end
            rd(7'h10, v); chk("R4 ready held", v, 32'h1);
            wr(7'h10, 32'h0);
            rd(7'h10, v); chk("R5 write zero keeps ready", v, 32'h1);
            wr(7'h10, 32'h1);
            rd(7'h10, v); chk("R5 ready cleared", v, 32'h0);
        end
        chk("R5 refill requested", {31'd0, gen_req}, 32'h1);
        wr(7'h14, 32'h0);
        tick();
        chk("R9 request stops", {31'd0, gen_req}, 32'h0);

        // R6 R7 R8 per-cause sweep
        for (int m = 0; m < 2; m++) begin
            for (int b = 1; b < 8; b++) begin
                logic [31:0] bit_b;
                bit_b = 32'h1 << b;
                wr(7'h14, (m == 1) ? bit_b : 32'h0);
                health_evt = 7'(1 << (b - 1));
                tick();
                health_evt = '0;
                rd(7'h10, v); chk("R6 cause captured", v, bit_b);
                chk("R8 irq gating", {31'd0, irq}, 32'(m));
                wr(7'h10, ~bit_b & 32'hFE);
                rd(7'h10, v); chk("R7 write zero keeps", v, bit_b);
                chk("R8 irq level held", {31'd0, irq}, 32'(m));
                wr(7'h10, bit_b);
                rd(7'h10, v); chk("R7 write one clears", v, 32'h0);
                chk("R8 irq drops", {31'd0, irq}, 32'h0);
            end
        end

        // R6 event wins over clear in the same cycle
        health_evt = 7'b0000100;
        wr(7'h10, 32'h08);
        health_evt = '0;
        rd(7'h10, v); chk("R6 event wins", v, 32'h08);

        // R8 several causes, only one enabled
        health_evt = 7'h7F;
        tick();
        health_evt = '0;
        wr(7'h14, 32'h10);
        rd(7'h10, v); chk("R6 all causes", v, 32'hFE);
        chk("R8 irq one enabled", {31'd0, irq}, 32'h1);
        wr(7'h10, 32'h10);
        chk("R8 irq off other causes pending", {31'd0, irq}, 32'h0);
        rd(7'h10, v); chk("R7 selective clear", v, 32'hEE);
        wr(7'h10, 32'hFE);
        rd(7'h10, v); chk("R7 clear all", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule